// File: doc/BRIEF.md
# Mixed-Decay H-Bridge Chopper Controller

This block is the digital control core of a two-input full-bridge motor driver. Two command bits select forward drive, reverse drive, brake or coast. The block turns that choice into four gate enables, one high switch and one low switch on each of the two bridge outputs. The current-sense comparator, the reference scaling and the gate supply live outside the block. It sees only a trip flag, which says the load current has reached its limit, and a zero-current flag.

When the trip flag is seen during forward or reverse drive, the block runs one fixed off-time of current chopping. The first half is fast decay, with the opposite diagonal of the bridge switched on. The second half is slow decay, with both low switches on. Every handover between drive, fast decay and slow decay passes through a dead-time gap with all four switches off. The trip flag is ignored for a blanking window after each drive turn-on. If the zero-current flag rises during an off-time, recirculation through the switches stops for the rest of that off-time, so the load current cannot reverse. All times are counted in clock cycles against parameters. The defaults are 375, 3125 and 50 cycles, which at 125 MHz give 3 us of blanking, 25 us of off-time and 400 ns of dead time.

A global enable forces all gates off in the same cycle it falls, and it returns the controller to idle.

Top module: `hbridge_chopper`

## Requirements
- R1: With the applied command forward ({cmd_a,cmd_b} = 2'b10), only gate_ah and gate_bl are on.
- R2: With the applied command reverse ({cmd_a,cmd_b} = 2'b01), only gate_bh and gate_al are on.
- R3: With the applied command brake ({cmd_a,cmd_b} = 2'b11), only gate_al and gate_bl are on.
- R4: With the applied command coast ({cmd_a,cmd_b} = 2'b00), all four gates are off. Coast is the applied command after reset. A trip in coast has no effect.
- R5: After the drive pattern first appears, trip is ignored for BLANK_CYC cycles. If trip is held from the start, the drive pattern lasts BLANK_CYC+1 cycles. Trip has no effect while brake or coast is applied.
- R6: An accepted trip produces, in order: DEAD_CYC cycles with all gates off, then OFF_CYC/2 cycles of fast decay (the opposite diagonal: gate_bh and gate_al for forward, gate_ah and gate_bl for reverse), then DEAD_CYC cycles off, then OFF_CYC-OFF_CYC/2 cycles of slow decay (gate_al and gate_bl), then DEAD_CYC cycles off, then drive again.
- R7: If zero_i is high in any clock cycle of an off-time, all gates are off from the next cycle until the off-time ends. The off-time keeps its length.
- R8: When the command inputs differ from the applied command outside an off-time, DEAD_CYC cycles with all gates off come first, and then the new pattern starts. A change made during an off-time is held back until the off-time ends, and it takes effect at the end of the final gap with no extra gap. A command change takes priority over a trip in the same cycle.
- R9: While en is low, all gates are off in the same cycle. The applied command returns to coast, and any off-time in progress is dropped. When en rises again, a non-coast command passes through a DEAD_CYC gap before it is applied.
- R10: The high and low gate of the same output are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; low forces all gates off and idles the controller |
| cmd_a | input | 1 | Command bit A (first bit of the 2-bit command) |
| cmd_b | input | 1 | Command bit B (second bit of the 2-bit command) |
| trip | input | 1 | Current-limit comparator flag |
| zero_i | input | 1 | Load-current zero-crossing flag |
| gate_ah | output | 1 | High switch of output A |
| gate_al | output | 1 | Low switch of output A |
| gate_bh | output | 1 | High switch of output B |
| gate_bl | output | 1 | Low switch of output B |

## Verification
The bench holds trip high from the start of forward drive. This measures the blanking window and the full gap, fast, gap, slow, gap sequence cycle by cycle. Running the same sequence in reverse tells the two fast-decay diagonals apart. A single trip pulse inside the blanking window, and trip held high during brake and during coast, show that trip is ignored there. A one-cycle zero-current pulse in mid fast decay tells a sticky cutoff, one that holds to the end of the off-time, from one that follows the pulse. A command change in mid slow decay tells a deferred handover from an immediate one. Dropping enable once during steady drive and once during fast decay shows the immediate cutoff and the return to idle with a fresh gap.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_GAP  = 2'd1,
    ST_FAST = 2'd2,
    ST_SLOW = 2'd3
  } hbc_state_t;

  typedef logic [1:0] hbc_cmd_t;

  localparam hbc_cmd_t CMD_COAST = 2'b00;
  localparam hbc_cmd_t CMD_REV   = 2'b01;
  localparam hbc_cmd_t CMD_FWD   = 2'b10;
  localparam hbc_cmd_t CMD_BRAKE = 2'b11;

  typedef struct packed {
    logic ah;
    logic al;
    logic bh;
    logic bl;
  } hbc_gates_t;

  localparam hbc_gates_t GATES_OFF = '0;

  function automatic int fast_len(int off_cyc);
    return off_cyc / 2;
  endfunction

  function automatic int slow_len(int off_cyc);
    return off_cyc - (off_cyc / 2);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cnt_bits(int maxval);
    int b;
    b = $clog2(maxval + 1);
    return (b < 1) ? 1 : b;
  endfunction

  function automatic logic is_drive(hbc_cmd_t c);
    return (c == CMD_FWD) || (c == CMD_REV);
  endfunction

  function automatic hbc_gates_t run_gates(hbc_cmd_t c);
    hbc_gates_t g;
    g = GATES_OFF;
    case (c)
      CMD_FWD:   begin g.ah = 1'b1; g.bl = 1'b1; end
      CMD_REV:   begin g.bh = 1'b1; g.al = 1'b1; end
      CMD_BRAKE: begin g.al = 1'b1; g.bl = 1'b1; end
      default:   g = GATES_OFF;
    endcase
    return g;
  endfunction

  function automatic hbc_gates_t fast_gates(hbc_cmd_t c);
    hbc_gates_t g;
    g = GATES_OFF;
    case (c)
      CMD_FWD: begin g.bh = 1'b1; g.al = 1'b1; end
      CMD_REV: begin g.ah = 1'b1; g.bl = 1'b1; end
      default: g = GATES_OFF;
    endcase
    return g;
  endfunction

  function automatic hbc_gates_t slow_gates();
    hbc_gates_t g;
    g = GATES_OFF;
    g.al = 1'b1;
    g.bl = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/hbc_timer.sv
module hbc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // a counter that is not reloaded never moves away from zero
  AST_TMR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done); // R6

endmodule

// File: rtl/hbc_seq.sv
module hbc_seq
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 375,
  parameter int OFF_CYC   = 3125,
  parameter int DEAD_CYC  = 50,
  parameter int W         = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  hbc_cmd_t    cmd,
  input  logic        trip,
  input  logic        zero_i,
  input  logic        tmr_done,
  output logic        tmr_load,
  output logic [W-1:0] tmr_val,
  output hbc_state_t  st,
  output hbc_cmd_t    act,
  output logic        zc_cut
);

  localparam logic [W-1:0] LD_BLANK = W'(BLANK_CYC);
  localparam logic [W-1:0] LD_DEAD  = W'(DEAD_CYC - 1);
  localparam logic [W-1:0] LD_FAST  = W'(fast_len(OFF_CYC) - 1);
  localparam logic [W-1:0] LD_SLOW  = W'(slow_len(OFF_CYC) - 1);

  hbc_state_t st_q, st_n;
  hbc_state_t after_q, after_n;
  hbc_cmd_t   act_q, act_n;
  logic       off_q, off_n;
  logic       zc_q, zc_n;

  // named events for the checks
  logic cmd_differs;
  logic trip_ok;
  assign cmd_differs = (cmd != act_q);
  assign trip_ok     = is_drive(act_q) && trip && tmr_done;

  always_comb begin
    st_n     = st_q;
    after_n  = after_q;
    act_n    = act_q;
    off_n    = off_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!en) begin
      st_n     = ST_RUN;
      after_n  = ST_RUN;
      act_n    = CMD_COAST;
      off_n    = 1'b0;
      tmr_load = 1'b1;
      tmr_val  = '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (cmd_differs) begin
            st_n     = ST_GAP;
            after_n  = ST_RUN;
            tmr_load = 1'b1;
            tmr_val  = LD_DEAD;
          end else if (trip_ok) begin
            st_n     = ST_GAP;
            after_n  = ST_FAST;
            off_n    = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = LD_DEAD;
          end
        end
        ST_GAP: begin
          if (tmr_done) begin
            tmr_load = 1'b1;
            case (after_q)
              ST_FAST: begin
                st_n    = ST_FAST;
                tmr_val = LD_FAST;
              end
              ST_SLOW: begin
                st_n    = ST_SLOW;
                tmr_val = LD_SLOW;
              end
              default: begin
                st_n    = ST_RUN;
                act_n   = cmd;
                off_n   = 1'b0;
                tmr_val = LD_BLANK;
              end
            endcase
          end
        end
        ST_FAST: begin
          if (tmr_done) begin
            st_n     = ST_GAP;
            after_n  = ST_SLOW;
            tmr_load = 1'b1;
            tmr_val  = LD_DEAD;
          end
        end
        default: begin
          if (tmr_done) begin
            st_n     = ST_GAP;
            after_n  = ST_RUN;
            tmr_load = 1'b1;
            tmr_val  = LD_DEAD;
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!off_n) begin
      zc_n = 1'b0;
    end else if (zero_i) begin
      zc_n = 1'b1;
    end else begin
      zc_n = zc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      after_q <= ST_RUN;
      act_q   <= CMD_COAST;
      off_q   <= 1'b0;
      zc_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      after_q <= after_n;
      act_q   <= act_n;
      off_q   <= off_n;
      zc_q    <= zc_n;
    end
  end

  assign st     = st_q;
  assign act    = act_q;
  assign zc_cut = zc_q;

  AST_FAST_FROM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAST && $past(st_q) != ST_FAST) |-> ($past(st_q) == ST_GAP)); // R6

  AST_SLOW_FROM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLOW && $past(st_q) != ST_SLOW) |-> ($past(st_q) == ST_GAP)); // R6

  AST_TRIP_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && after_q == ST_FAST && $past(st_q) == ST_RUN) |-> $past(tmr_done)); // R5

  AST_ZC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_q && en && st_q != ST_GAP) |=> zc_q); // R7

  AST_OFF_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (st_q == ST_FAST || st_q == ST_SLOW)) |=> $stable(act_q)); // R8

endmodule

// File: rtl/hbc_gate_map.sv
module hbc_gate_map
  import hbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  hbc_state_t st,
  input  hbc_cmd_t   act,
  input  logic       zc_cut,
  output hbc_gates_t gates
);

  hbc_gates_t raw;

  always_comb begin
    case (st)
      ST_RUN:  raw = run_gates(act);
      ST_FAST: raw = zc_cut ? GATES_OFF : fast_gates(act);
      ST_SLOW: raw = zc_cut ? GATES_OFF : slow_gates();
      default: raw = GATES_OFF;
    endcase
    gates = en ? raw : GATES_OFF;
  end

  logic [1:0] leg_hi;
  logic [1:0] leg_lo;
  assign leg_hi = {gates.ah, gates.bh};
  assign leg_lo = {gates.al, gates.bl};

  for (genvar k = 0; k < 2; k++) begin : g_leg
    AST_LEG_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(leg_hi[k] && leg_lo[k])); // R10
  end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 375,
  parameter int OFF_CYC   = 3125,
  parameter int DEAD_CYC  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic trip,
  input  logic zero_i,
  output logic gate_ah,
  output logic gate_al,
  output logic gate_bh,
  output logic gate_bl
);

  localparam int MAXV = max2(max2(BLANK_CYC, DEAD_CYC),
                             max2(fast_len(OFF_CYC), slow_len(OFF_CYC)));
  localparam int W    = cnt_bits(MAXV);

  logic         tmr_load;
  logic [W-1:0] tmr_val;
  logic         tmr_done;
  hbc_state_t   st;
  hbc_cmd_t     act;
  logic         zc_cut;
  hbc_gates_t   gates;

  hbc_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  hbc_seq #(
    .BLANK_CYC (BLANK_CYC),
    .OFF_CYC   (OFF_CYC),
    .DEAD_CYC  (DEAD_CYC),
    .W         (W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cmd      ({cmd_a, cmd_b}),
    .trip     (trip),
    .zero_i   (zero_i),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .st       (st),
    .act      (act),
    .zc_cut   (zc_cut)
  );

  hbc_gate_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .st     (st),
    .act    (act),
    .zc_cut (zc_cut),
    .gates  (gates)
  );

  assign gate_ah = gates.ah;
  assign gate_al = gates.al;
  assign gate_bh = gates.bh;
  assign gate_bl = gates.bl;

  AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gates) != GATES_OFF && gates != GATES_OFF) |-> (gates == $past(gates))); // R8

  AST_EN_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gates == GATES_OFF)); // R9

endmodule

// File: tb/hbridge_chopper_bench.sv
module hbridge_chopper_bench;

  localparam int BLANK = 6;
  localparam int OFF   = 20;
  localparam int DEAD  = 3;
  localparam int FASTN = OFF / 2;
  localparam int SLOWN = OFF - OFF / 2;

  localparam logic [3:0] P_OFF = 4'b0000;
  localparam logic [3:0] P_FWD = 4'b1001;
  localparam logic [3:0] P_REV = 4'b0110;
  localparam logic [3:0] P_LOW = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic cmd_a = 1'b0;
  logic cmd_b = 1'b0;
  logic trip = 1'b0;
  logic zero_i = 1'b0;
  logic gate_ah, gate_al, gate_bh, gate_bl;

  int vectors = 0;
  int miss = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  hbridge_chopper #(
    .BLANK_CYC (BLANK),
    .OFF_CYC   (OFF),
    .DEAD_CYC  (DEAD)
  ) u_hbridge_chopper (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cmd_a   (cmd_a),
    .cmd_b   (cmd_b),
    .trip    (trip),
    .zero_i  (zero_i),
    .gate_ah (gate_ah),
    .gate_al (gate_al),
    .gate_bh (gate_bh),
    .gate_bl (gate_bl)
  );

  function automatic logic [3:0] got_now();
    return {gate_ah, gate_al, gate_bh, gate_bl};
  endfunction

  task automatic direct_check(logic [3:0] exp, string tag);
    vectors++;
    if (got_now() !== exp) begin
      miss++;
      $display("FAIL %s: got %b expected %b", tag, got_now(), exp);
    end
  endtask

  // push n expected samples, then let them play out
  task automatic expect_run(logic [3:0] pat, int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat);
      tag_q.push_back(tag);
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(logic [1:0] c);
    cmd_a = c[1];
    cmd_b = c[0];
  endtask

  // monitor: one sample per cycle, just after the active edge
  initial begin
    logic [3:0] e;
    logic [3:0] g;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = got_now();
        vectors++;
        if (g !== e) begin
          miss++;
          $display("FAIL %s: got %b expected %b", t, g, e);
        end
        vectors++;
        if ((g[3] && g[2]) || (g[1] && g[0])) begin
          miss++;
          $display("FAIL R10 shoot-through: got %b expected no leg with both on", g);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog: got timeout expected end of run");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct_check(P_OFF, "R4 reset state");
    rst_n = 1'b1;
    expect_run(P_OFF, 4, "R4 coast after reset");

    // forward, trip held from the start: blanking then full off-time
    set_cmd(2'b10);
    expect_run(P_OFF, DEAD, "R8 gap before forward");
    trip = 1'b1;
    expect_run(P_FWD, BLANK + 1, "R5 R1 forward through blanking");
    expect_run(P_OFF, DEAD, "R6 gap before fast");
    trip = 1'b0;
    expect_run(P_REV, FASTN, "R6 fast decay forward");
    expect_run(P_OFF, DEAD, "R6 gap before slow");
    expect_run(P_LOW, SLOWN, "R6 slow decay");
    expect_run(P_OFF, DEAD, "R6 gap after slow");
    expect_run(P_FWD, 12, "R1 forward resumes");

    // reverse, trip pulse inside blanking is ignored
    set_cmd(2'b01);
    expect_run(P_OFF, DEAD, "R8 gap before reverse");
    expect_run(P_REV, 2, "R2 reverse");
    trip = 1'b1;
    expect_run(P_REV, 1, "R5 pulse in blanking");
    trip = 1'b0;
    expect_run(P_REV, 15, "R5 R2 reverse holds after pulse");

    // reverse trip with a zero-current pulse in mid fast decay
    trip = 1'b1;
    expect_run(P_OFF, DEAD, "R6 gap before fast reverse");
    trip = 1'b0;
    expect_run(P_FWD, 4, "R6 fast decay reverse");
    zero_i = 1'b1;
    expect_run(P_OFF, 1, "R7 zero cut");
    zero_i = 1'b0;
    expect_run(P_OFF, 21, "R7 cut holds to end of off-time");
    expect_run(P_REV, 10, "R2 reverse resumes");

    // command change during slow decay is deferred
    trip = 1'b1;
    expect_run(P_OFF, DEAD, "R6 gap before fast");
    trip = 1'b0;
    expect_run(P_FWD, FASTN, "R6 fast decay reverse");
    expect_run(P_OFF, DEAD, "R6 gap before slow");
    expect_run(P_LOW, 3, "R6 slow decay");
    set_cmd(2'b10);
    expect_run(P_LOW, SLOWN - 3, "R8 deferred change keeps slow decay");
    expect_run(P_OFF, DEAD, "R8 final gap");
    expect_run(P_FWD, 8, "R8 new command after off-time");

    // brake ignores trip
    set_cmd(2'b11);
    expect_run(P_OFF, DEAD, "R8 gap before brake");
    trip = 1'b1;
    expect_run(P_LOW, 20, "R3 R5 brake ignores trip");

    // coast ignores trip
    set_cmd(2'b00);
    expect_run(P_OFF, DEAD, "R8 gap before coast");
    expect_run(P_OFF, 10, "R4 coast ignores trip");
    trip = 1'b0;

    // enable drop in steady drive
    set_cmd(2'b10);
    expect_run(P_OFF, DEAD, "R8 gap before forward");
    expect_run(P_FWD, 8, "R1 forward");
    en = 1'b0;
    #1;
    direct_check(P_OFF, "R9 immediate cutoff");
    expect_run(P_OFF, 5, "R9 held off");
    en = 1'b1;
    expect_run(P_OFF, DEAD, "R9 restart gap");
    expect_run(P_FWD, 8, "R9 forward after restart");

    // enable drop inside fast decay drops the off-time
    trip = 1'b1;
    expect_run(P_OFF, DEAD, "R6 gap before fast");
    trip = 1'b0;
    expect_run(P_REV, 5, "R6 fast decay forward");
    en = 1'b0;
    expect_run(P_OFF, 4, "R9 off-time dropped");
    en = 1'b1;
    expect_run(P_OFF, DEAD, "R9 restart gap from idle");
    expect_run(P_FWD, 8, "R9 forward from idle");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      miss++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

endmodule